// File: doc/BRIEF.md
# Mezzanine Slot Identifier Register

This block holds a single 8-bit register that gives a 5-bit identifier to each of two mezzanine slots on a carrier board. Both identifiers share their upper four bits. Each slot has its own least-significant bit, so the two identifiers always differ unless software chooses otherwise.

The reset value is not a constant. While reset is held, the register takes its shared upper bits from the low four bits of the backplane geographic address. It sets slot 1's low bit and clears slot 2's low bit. The address value captured at the last reset edge stays in place. Later changes on the address pins have no effect until the next reset.

After reset, software can write the register through a small register bus to assign any identifiers, for example to make every module in a chassis unique. The same bus reads the register back. The two identifier outputs are assembled from the register at all times.

Top module: `slot_id_reg`

## Requirements
- R1: At the clock edge that ends reset, slot 1 ID becomes {ga[3:0], 1} and slot 2 ID becomes {ga[3:0], 0}. Here ga is the value on the geographic address input at the last clock edge with reset low, and ga[4] is not used.
- R2: Changes on the geographic address input after reset is released do not change either ID output or the readback value.
- R3: Slot 1 ID is {reg[5:2], reg[0]} and slot 2 ID is {reg[5:2], reg[1]}, so bits 4..1 of the two IDs are always equal.
- R4: A write with `wr_en` high and `addr` equal to 0x8 (4-bit address, 16-byte window) loads `wdata[5:0]` into register bits 5..0, visible on the outputs one clock after the write edge.
- R5: Write data bits 7 and 6 are discarded, and readback bits 7 and 6 are always zero.
- R6: While `addr` equals 0x8, `rdata` shows {2'b00, reg[5:0]} combinationally.
- R7: At any address other than 0x8, `rdata` is zero and writes leave both IDs unchanged.
- R8: With no write to offset 0x8, the register and both IDs hold their value from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the geographic default |
| addr | input | 4 | Register bus byte address within the 16-byte window |
| wr_en | input | 1 | Write strobe, taken on the rising clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed byte |
| geo_addr | input | 5 | Backplane geographic address |
| slot1_id | output | 5 | Identifier presented to mezzanine slot 1 |
| slot2_id | output | 5 | Identifier presented to mezzanine slot 2 |

## Verification
The assertions check the following on every cycle:
- the upper identifier bits are shared by both slots;
- readback bits 7..6 are zero;
- readback at offset 0x8 agrees with the two outputs;
- a miss address reads zero;
- a write hit lands one cycle later;
- a cycle with no hit leaves the outputs stable;
- the first cycle after reset carries the captured geographic bits.

The bench alone shows that the outputs ignore later movement of the geographic pins. It sweeps every geographic address and every write byte. It probes all fifteen miss addresses, with expected values worked out from the bit layout.

// File: rtl/slotid_pkg.sv
package slotid_pkg;

    typedef enum logic [1:0] {
        ACC_NONE    = 2'd0,
        ACC_WR_HIT  = 2'd1,
        ACC_WR_MISS = 2'd2
    } acc_e;

    // Reset value of a slot's private low ID bit: only the first slot is set.
    function automatic logic lsb_default(input int slot_idx);
        return (slot_idx == 0);
    endfunction

endpackage

// File: rtl/slotid_decode.sv
module slotid_decode #(
    parameter int ADDR_W = 4,
    parameter int OFFSET = 8
) (
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    output logic                 hit,
    output slotid_pkg::acc_e     acc
);
    localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(OFFSET);

    always_comb begin
        hit = (addr == MATCH);
        if (!wr_en)
            acc = slotid_pkg::ACC_NONE;
        else if (hit)
            acc = slotid_pkg::ACC_WR_HIT;
        else
            acc = slotid_pkg::ACC_WR_MISS;
    end
endmodule

// File: rtl/slotid_field.sv
module slotid_field #(
    parameter int COMMON_W  = 4,
    parameter int NUM_SLOTS = 2,
    localparam int FIELD_W  = COMMON_W + NUM_SLOTS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  slotid_pkg::acc_e     acc,
    input  logic [FIELD_W-1:0]   wbits,
    input  logic [COMMON_W-1:0]  geo_low,
    output logic [FIELD_W-1:0]   field
);
    typedef struct packed {
        logic [COMMON_W-1:0]  common;
        logic [NUM_SLOTS-1:0] lsb;
    } field_t;

    field_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.common = geo_low;
            for (int k = 0; k < NUM_SLOTS; k++)
                st_d.lsb[k] = slotid_pkg::lsb_default(k);
        end else if (acc == slotid_pkg::ACC_WR_HIT) begin
            st_d = field_t'(wbits);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign field = st_q;
endmodule

// File: rtl/slotid_idmap.sv
module slotid_idmap #(
    parameter int COMMON_W  = 4,
    parameter int NUM_SLOTS = 2,
    localparam int FIELD_W  = COMMON_W + NUM_SLOTS,
    localparam int ID_W     = COMMON_W + 1
) (
    input  logic [FIELD_W-1:0]          field,
    output logic [NUM_SLOTS*ID_W-1:0]   ids
);
    logic [COMMON_W-1:0] common_bits;
    assign common_bits = field[FIELD_W-1:NUM_SLOTS];

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        assign ids[k*ID_W +: ID_W] = {common_bits, field[k]};
    end
endmodule

// File: rtl/slotid_readmux.sv
module slotid_readmux #(
    parameter int FIELD_W = 6,
    parameter int DATA_W  = 8,
    localparam int PAD_W  = DATA_W - FIELD_W
) (
    input  logic                hit,
    input  logic [FIELD_W-1:0]  field,
    output logic [DATA_W-1:0]   rdata
);
    always_comb begin
        if (hit)
            rdata = {{PAD_W{1'b0}}, field};
        else
            rdata = '0;
    end
endmodule

// File: rtl/slot_id_reg.sv
module slot_id_reg #(
    parameter int ADDR_W = 4,
    parameter int OFFSET = 8,
    parameter int DATA_W = 8,
    parameter int GA_W   = 5,
    parameter int ID_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [GA_W-1:0]   geo_addr,
    output logic [ID_W-1:0]   slot1_id,
    output logic [ID_W-1:0]   slot2_id
);
    localparam int NUM_SLOTS = 2;
    localparam int COMMON_W  = ID_W - 1;
    localparam int FIELD_W   = COMMON_W + NUM_SLOTS;

    logic                       hit;
    slotid_pkg::acc_e           acc;
    logic [FIELD_W-1:0]         field;
    logic [NUM_SLOTS*ID_W-1:0]  ids;

    logic unused_wdata_hi;
    logic unused_geo_hi;
    assign unused_wdata_hi = ^wdata[DATA_W-1:FIELD_W];
    assign unused_geo_hi   = ^geo_addr[GA_W-1:COMMON_W];

    slotid_decode #(.ADDR_W(ADDR_W), .OFFSET(OFFSET)) u_decode (
        .wr_en (wr_en),
        .addr  (addr),
        .hit   (hit),
        .acc   (acc)
    );

    slotid_field #(.COMMON_W(COMMON_W), .NUM_SLOTS(NUM_SLOTS)) u_field (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (acc),
        .wbits   (wdata[FIELD_W-1:0]),
        .geo_low (geo_addr[COMMON_W-1:0]),
        .field   (field)
    );

    slotid_idmap #(.COMMON_W(COMMON_W), .NUM_SLOTS(NUM_SLOTS)) u_idmap (
        .field (field),
        .ids   (ids)
    );

    slotid_readmux #(.FIELD_W(FIELD_W), .DATA_W(DATA_W)) u_readmux (
        .hit   (hit),
        .field (field),
        .rdata (rdata)
    );

    assign slot1_id = ids[0 +: ID_W];
    assign slot2_id = ids[ID_W +: ID_W];
endmodule

// File: rtl/slot_id_reg_chk.sv
module slot_id_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] addr,
    input logic       wr_en,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic [4:0] geo_addr,
    input logic [4:0] slot1_id,
    input logic [4:0] slot2_id
);
    p_reset_default_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n)) |-> (slot1_id == {$past(geo_addr[3:0]), 1'b1}
                             && slot2_id == {$past(geo_addr[3:0]), 1'b0}));

    p_shared_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
        slot1_id[4:1] == slot2_id[4:1]);

    p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 4'h8) |=> (slot1_id == {$past(wdata[5:2]), $past(wdata[0])}
                                     && slot2_id == {$past(wdata[5:2]), $past(wdata[1])}));

    p_pad_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[7:6] == 2'b00);

    p_readback_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 4'h8) |-> rdata[5:0] == {slot1_id[4:1], slot2_id[0], slot1_id[0]});

    p_miss_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != 4'h8) |-> rdata == 8'h00);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && addr == 4'h8)) |=> ($stable(slot1_id) && $stable(slot2_id)));
endmodule

bind slot_id_reg slot_id_reg_chk u_chk (.*);

// File: tb/slot_id_reg_test.sv
module slot_id_reg_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = 4'h0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [4:0] geo_addr = 5'h00;
    logic [4:0] slot1_id;
    logic [4:0] slot2_id;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    slot_id_reg uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .geo_addr(geo_addr), .slot1_id(slot1_id), .slot2_id(slot2_id)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic [5:0] fld);
        check(req, {3'b0, slot1_id}, {3'b0, fld[5:2], fld[0]});
        check(req, {3'b0, slot2_id}, {3'b0, fld[5:2], fld[1]});
        addr = 4'h8;
        #1;
        check(req, rdata, {2'b00, fld});
    endtask

    task automatic do_reset(input logic [4:0] g);
        @(negedge clk);
        rst_n = 1'b0;
        geo_addr = g;
        @(negedge clk);
        rst_n = 1'b1;
        geo_addr = ~g;
    endtask

    task automatic do_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        logic [5:0] cur;
        repeat (3) @(negedge clk);

        // R1 / R2: every geographic address, then pins move after release
        for (int g = 0; g < 32; g++) begin
            do_reset(5'(g));
            cur = {4'(g), 2'b01};
            check_all("R1", cur);
            @(negedge clk);
            geo_addr = 5'(g) ^ 5'h0f;
            @(negedge clk);
            check_all("R2", cur);
        end

        // R3 / R4 / R5 / R6: every write byte
        for (int v = 0; v < 256; v++) begin
            do_write(4'h8, 8'(v));
            cur = 6'(v);
            check_all((v >= 64) ? "R5" : "R4", cur);
            check("R3", {3'b0, slot1_id[4:1]}, {3'b0, slot2_id[4:1]});
        end

        // R7: every other address ignores writes and reads zero
        do_write(4'h8, 8'h2a);
        cur = 6'h2a;
        for (int a = 0; a < 16; a++) begin
            if (a != 8) begin
                do_write(4'(a), 8'hd5);
                addr = 4'(a);
                #1;
                check("R7", rdata, 8'h00);
                check_all("R7", cur);
            end
        end

        // R8: idle cycles with stray data hold the value
        @(negedge clk);
        wdata = 8'hff;
        addr = 4'h8;
        repeat (5) @(negedge clk);
        check_all("R8", cur);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule